// File: doc/BRIEF.md
# Classic Shared-Bus Cycle Master

This block drives one classic Wishbone bus as its only master. The user side starts a transfer with a single start pulse. The transfer is one of three kinds: a single beat, a block of one to eight beats, or a read-modify-write of one address. Before a transfer starts, the user fills a small table of address/data pairs. Single and read-modify-write transfers use entry 0. A block transfer walks the entries from 0 upward.

Each beat lasts until the slave answers with acknowledge, error or retry. Every beat then reports its outcome and the sampled read data on the user side. After the last beat the bus is parked at zero for one cycle. At that point a done pulse appears, together with a flag that is set when any beat ended without an acknowledge. Error and retry do not cut a block short.

Top module: `wbc_master`

## Requirements
- R1: While reset is sampled high, the following clock leaves `wb_cyc`, `wb_stb`, `busy` and `done` low.
- R2: A `cmd_start` accepted while `busy` is low raises `wb_cyc` and `wb_stb` together on the next clock. In that cycle `wb_adr` and `wb_dat_o` carry table entry 0. `wb_we` equals `cmd_we` for single and block modes. The mode encodings are 0 single, 1 block, 2 read-modify-write, and 3 acts as single.
- R3: A beat ends on the clock edge where any of `wb_ack`, `wb_err` or `wb_rty` is high. In the next cycle `st_valid` is high for one cycle and shows the beat index, the read data sampled on that edge, and `st_code` (1 ack, 2 err, 3 rty; when several are high, ack wins over err and err wins over rty).
- R4: While `wb_stb` is high and no termination is present, `wb_adr`, `wb_dat_o`, `wb_sel`, `wb_we` and `wb_stb` do not change on the next clock.
- R5: A block transfer runs `cmd_beats_m1`+1 beats. Beat k uses table entry k. `wb_cyc` stays high without a break from the first beat to the last.
- R6: After the final beat ends, `wb_cyc`, `wb_stb`, `wb_we`, `wb_sel`, `wb_adr` and `wb_dat_o` are all zero for one cycle. `done` pulses in that cycle, and `busy` falls on the cycle after it.
- R7: A read-modify-write does a read beat (`wb_we` low) and then a write beat (`wb_we` high) to the same address within one `wb_cyc` assertion. The write data is (read data OR `cmd_set`) AND NOT `cmd_clr`.
- R8: Error and retry terminations do not stop a transfer; all remaining beats still run. `done_fail`, valid with `done`, is 1 exactly when at least one beat ended without acknowledge.
- R9: A `cmd_start` that arrives while `busy` is high is ignored. No extra beat and no new `wb_cyc` assertion follows the running transfer.
- R10: `wb_stb` is never high while `wb_cyc` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_wr | input | 1 | Write one table entry |
| tbl_idx | input | IW | Table entry index |
| tbl_adr | input | AW | Address for the entry |
| tbl_dat | input | DW | Write data for the entry |
| cmd_start | input | 1 | Start a transfer (taken when not busy) |
| cmd_mode | input | 2 | 0 single, 1 block, 2 read-modify-write |
| cmd_beats_m1 | input | IW | Block beat count minus one |
| cmd_we | input | 1 | Write direction for single/block |
| cmd_set | input | DW | Bits forced to 1 in read-modify-write |
| cmd_clr | input | DW | Bits forced to 0 in read-modify-write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| done_fail | output | 1 | Some beat ended without acknowledge |
| st_valid | output | 1 | Per-beat status valid |
| st_idx | output | IW | Index of the reported beat |
| st_code | output | 2 | 1 ack, 2 err, 3 rty |
| st_rdata | output | DW | Read data sampled at the beat's end |
| wb_cyc | output | 1 | Bus cycle |
| wb_stb | output | 1 | Strobe |
| wb_we | output | 1 | Write enable |
| wb_adr | output | AW | Address |
| wb_dat_o | output | DW | Write data |
| wb_sel | output | DW/8 | Byte selects |
| wb_ack | input | 1 | Slave acknowledge |
| wb_err | input | 1 | Slave error |
| wb_rty | input | 1 | Slave retry |
| wb_dat_i | input | DW | Slave read data |

## Verification
The hardest state to reach is a block in which beats end in different ways and after different waits, while the strobe is held through long stalls. The bench slave model takes a wait count and a response code for each beat. This lets one block mix an immediate acknowledge, a stalled error and a retry. The bench samples every cycle of the transfer and counts any change of address, data or direction during a stall. It counts rising edges of the cycle signal to confirm the transfer stays unbroken. It also raises a second start in the middle of a stalled beat to show that the command is dropped.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

    typedef enum logic [1:0] {
        XF_SINGLE = 2'd0,
        XF_BLOCK  = 2'd1,
        XF_RMW    = 2'd2
    } xfer_mode_e;

    typedef enum logic [1:0] {
        TC_NONE = 2'd0,
        TC_ACK  = 2'd1,
        TC_ERR  = 2'd2,
        TC_RTY  = 2'd3
    } term_code_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_BEAT,
        SQ_GAP
    } seq_state_e;

    function automatic xfer_mode_e decode_mode(input logic [1:0] raw);
        case (raw)
            2'd1:    return XF_BLOCK;
            2'd2:    return XF_RMW;
            default: return XF_SINGLE;
        endcase
    endfunction

endpackage

// File: rtl/wbc_beat_buf.sv
module wbc_beat_buf #(
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [AW-1:0] wr_adr,
    input  logic [DW-1:0] wr_dat,
    input  logic [IW-1:0] rd_idx,
    output logic [AW-1:0] rd_adr,
    output logic [DW-1:0] rd_dat
);
    logic [AW-1:0] adr_q [DEPTH];
    logic [DW-1:0] dat_q [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                adr_q[e] <= '0;
                dat_q[e] <= '0;
            end else if (wr_en && (wr_idx == IW'(e))) begin
                adr_q[e] <= wr_adr;
                dat_q[e] <= wr_dat;
            end
        end
    end

    assign rd_adr = adr_q[rd_idx];
    assign rd_dat = dat_q[rd_idx];
endmodule

// File: rtl/wbc_term_enc.sv
module wbc_term_enc
    import wbc_pkg::*;
(
    input  logic       ack,
    input  logic       err,
    input  logic       rty,
    output logic       any,
    output term_code_e code
);
    always_comb begin
        if (ack)      code = TC_ACK;
        else if (err) code = TC_ERR;
        else if (rty) code = TC_RTY;
        else          code = TC_NONE;
    end
    assign any = ack | err | rty;
endmodule

// File: rtl/wbc_seq.sv
module wbc_seq
    import wbc_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int IW = 3,
    localparam int SW = DW / 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [1:0]    mode,
    input  logic [IW-1:0] beats_m1,
    input  logic          we_cmd,
    input  logic [DW-1:0] set_mask,
    input  logic [DW-1:0] clr_mask,
    output logic [IW-1:0] buf_idx,
    input  logic [AW-1:0] buf_adr,
    input  logic [DW-1:0] buf_dat,
    input  logic          term_any,
    input  term_code_e    term_code,
    input  logic [DW-1:0] dat_in,
    output logic          cyc,
    output logic          stb,
    output logic          we,
    output logic [AW-1:0] adr,
    output logic [DW-1:0] dat_out,
    output logic [SW-1:0] sel,
    output logic          busy,
    output logic          done,
    output logic          done_fail,
    output logic          st_valid,
    output logic [IW-1:0] st_idx,
    output term_code_e    st_code,
    output logic [DW-1:0] st_rdata
);
    seq_state_e    state;
    xfer_mode_e    mode_q;
    logic [IW-1:0] idx_q, last_q;
    logic          fail_q;
    logic [DW-1:0] set_q, clr_q;
    xfer_mode_e    mode_in;
    logic          fail_nx;

    assign mode_in = decode_mode(mode);
    assign fail_nx = fail_q | (term_code != TC_ACK);
    assign buf_idx = (state == SQ_IDLE) ? '0 : idx_q + IW'(1);
    assign busy    = (state != SQ_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SQ_IDLE;
            mode_q    <= XF_SINGLE;
            idx_q     <= '0;
            last_q    <= '0;
            fail_q    <= 1'b0;
            set_q     <= '0;
            clr_q     <= '0;
            cyc       <= 1'b0;
            stb       <= 1'b0;
            we        <= 1'b0;
            adr       <= '0;
            dat_out   <= '0;
            sel       <= '0;
            done      <= 1'b0;
            done_fail <= 1'b0;
            st_valid  <= 1'b0;
            st_idx    <= '0;
            st_code   <= TC_NONE;
            st_rdata  <= '0;
        end else begin
            done     <= 1'b0;
            st_valid <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        state   <= SQ_BEAT;
                        mode_q  <= mode_in;
                        cyc     <= 1'b1;
                        stb     <= 1'b1;
                        sel     <= '1;
                        we      <= (mode_in == XF_RMW) ? 1'b0 : we_cmd;
                        adr     <= buf_adr;
                        dat_out <= buf_dat;
                        idx_q   <= '0;
                        fail_q  <= 1'b0;
                        set_q   <= set_mask;
                        clr_q   <= clr_mask;
                        case (mode_in)
                            XF_BLOCK: last_q <= beats_m1;
                            XF_RMW:   last_q <= IW'(1);
                            default:  last_q <= '0;
                        endcase
                    end
                end
                SQ_BEAT: begin
                    if (term_any) begin
                        st_valid <= 1'b1;
                        st_idx   <= idx_q;
                        st_code  <= term_code;
                        st_rdata <= dat_in;
                        fail_q   <= fail_nx;
                        if (idx_q != last_q) begin
                            idx_q <= idx_q + IW'(1);
                            if (mode_q == XF_RMW) begin
                                we      <= 1'b1;
                                dat_out <= (dat_in | set_q) & ~clr_q;
                            end else begin
                                adr     <= buf_adr;
                                dat_out <= buf_dat;
                            end
                        end else begin
                            state     <= SQ_GAP;
                            cyc       <= 1'b0;
                            stb       <= 1'b0;
                            we        <= 1'b0;
                            sel       <= '0;
                            adr       <= '0;
                            dat_out   <= '0;
                            done      <= 1'b1;
                            done_fail <= fail_nx;
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wbc_master.sv
module wbc_master
    import wbc_pkg::*;
#(
    parameter int AW     = 16,
    parameter int DW     = 16,
    parameter int MAXB   = 8,
    localparam int IW    = (MAXB > 1) ? $clog2(MAXB) : 1,
    localparam int SW    = DW / 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tbl_wr,
    input  logic [IW-1:0] tbl_idx,
    input  logic [AW-1:0] tbl_adr,
    input  logic [DW-1:0] tbl_dat,
    input  logic          cmd_start,
    input  logic [1:0]    cmd_mode,
    input  logic [IW-1:0] cmd_beats_m1,
    input  logic          cmd_we,
    input  logic [DW-1:0] cmd_set,
    input  logic [DW-1:0] cmd_clr,
    output logic          busy,
    output logic          done,
    output logic          done_fail,
    output logic          st_valid,
    output logic [IW-1:0] st_idx,
    output logic [1:0]    st_code,
    output logic [DW-1:0] st_rdata,
    output logic          wb_cyc,
    output logic          wb_stb,
    output logic          wb_we,
    output logic [AW-1:0] wb_adr,
    output logic [DW-1:0] wb_dat_o,
    output logic [SW-1:0] wb_sel,
    input  logic          wb_ack,
    input  logic          wb_err,
    input  logic          wb_rty,
    input  logic [DW-1:0] wb_dat_i
);
    logic [IW-1:0] rd_idx;
    logic [AW-1:0] rd_adr;
    logic [DW-1:0] rd_dat;
    logic          t_any;
    term_code_e    t_code;
    term_code_e    st_code_e;

    wbc_beat_buf #(.AW(AW), .DW(DW), .DEPTH(MAXB)) u_buf (
        .clk(clk), .rst(rst),
        .wr_en(tbl_wr), .wr_idx(tbl_idx), .wr_adr(tbl_adr), .wr_dat(tbl_dat),
        .rd_idx(rd_idx), .rd_adr(rd_adr), .rd_dat(rd_dat)
    );

    wbc_term_enc u_term (
        .ack(wb_ack), .err(wb_err), .rty(wb_rty), .any(t_any), .code(t_code)
    );

    wbc_seq #(.AW(AW), .DW(DW), .IW(IW)) u_seq (
        .clk(clk), .rst(rst),
        .start(cmd_start), .mode(cmd_mode), .beats_m1(cmd_beats_m1),
        .we_cmd(cmd_we), .set_mask(cmd_set), .clr_mask(cmd_clr),
        .buf_idx(rd_idx), .buf_adr(rd_adr), .buf_dat(rd_dat),
        .term_any(t_any), .term_code(t_code), .dat_in(wb_dat_i),
        .cyc(wb_cyc), .stb(wb_stb), .we(wb_we), .adr(wb_adr),
        .dat_out(wb_dat_o), .sel(wb_sel),
        .busy(busy), .done(done), .done_fail(done_fail),
        .st_valid(st_valid), .st_idx(st_idx), .st_code(st_code_e),
        .st_rdata(st_rdata)
    );

    assign st_code = st_code_e;
endmodule

// File: rtl/wbc_master_chk.sv
module wbc_master_chk #(
    parameter int AW = 16,
    parameter int DW = 16,
    localparam int SW = DW / 8
) (
    input logic          clk,
    input logic          rst,
    input logic          done,
    input logic          st_valid,
    input logic          wb_cyc,
    input logic          wb_stb,
    input logic          wb_we,
    input logic [AW-1:0] wb_adr,
    input logic [DW-1:0] wb_dat_o,
    input logic [SW-1:0] wb_sel,
    input logic          wb_ack,
    input logic          wb_err,
    input logic          wb_rty
);
    logic term;
    assign term = wb_ack | wb_err | wb_rty;

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!wb_cyc && !wb_stb));

    // R10
    stb_in_cyc_chk: assert property (@(posedge clk) disable iff (rst)
        wb_stb |-> wb_cyc);

    // R4
    hold_while_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_stb && !term) |=> (wb_stb && $stable(wb_adr) && $stable(wb_dat_o)
                               && $stable(wb_we) && $stable(wb_sel)));

    // R6
    park_zero_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!wb_cyc && !wb_stb && !wb_we && wb_adr == '0
                  && wb_dat_o == '0 && wb_sel == '0 && $past(wb_cyc)));

    // R9
    idle_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(wb_cyc) |=> !wb_cyc);

    // R3
    status_after_term_chk: assert property (@(posedge clk) disable iff (rst)
        st_valid |-> $past(wb_stb && term));
endmodule

bind wbc_master wbc_master_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst(rst), .done(done), .st_valid(st_valid),
    .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
    .wb_dat_o(wb_dat_o), .wb_sel(wb_sel),
    .wb_ack(wb_ack), .wb_err(wb_err), .wb_rty(wb_rty)
);

// File: tb/wbc_master_bench.sv
`timescale 1ns/1ps
module wbc_master_bench;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tbl_wr = 1'b0;
    logic [IW-1:0] tbl_idx = '0;
    logic [AW-1:0] tbl_adr = '0;
    logic [DW-1:0] tbl_dat = '0;
    logic          cmd_start = 1'b0;
    logic [1:0]    cmd_mode = '0;
    logic [IW-1:0] cmd_beats_m1 = '0;
    logic          cmd_we = 1'b0;
    logic [DW-1:0] cmd_set = '0;
    logic [DW-1:0] cmd_clr = '0;
    logic          busy, done, done_fail, st_valid;
    logic [IW-1:0] st_idx;
    logic [1:0]    st_code;
    logic [DW-1:0] st_rdata;
    logic          wb_cyc, wb_stb, wb_we;
    logic [AW-1:0] wb_adr;
    logic [DW-1:0] wb_dat_o;
    logic [1:0]    wb_sel;
    logic          wb_ack, wb_err, wb_rty;
    logic [DW-1:0] wb_dat_i;

    always #4 clk = ~clk;

    wbc_master u_wbc_master (.*);

    // slave model
    int   wait_cfg [8];
    int   resp_cfg [8];
    logic slv_rst = 1'b1;
    int   s_cnt;
    int   s_beat;
    logic term;

    assign term     = wb_cyc && wb_stb && (s_cnt == wait_cfg[s_beat[2:0]]);
    assign wb_ack   = term && resp_cfg[s_beat[2:0]] == 1;
    assign wb_err   = term && resp_cfg[s_beat[2:0]] == 2;
    assign wb_rty   = term && resp_cfg[s_beat[2:0]] == 3;
    assign wb_dat_i = wb_adr ^ 16'hA5A5;

    always @(posedge clk) begin
        if (slv_rst) begin
            s_cnt  <= 0;
            s_beat <= 0;
        end else if (!(wb_cyc && wb_stb)) begin
            s_cnt <= 0;
        end else if (term) begin
            s_cnt  <= 0;
            s_beat <= s_beat + 1;
        end else begin
            s_cnt <= s_cnt + 1;
        end
    end

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // observations of one transfer
    int            n_beats, n_st, rises, chg, extra_cyc, stb_cycles;
    logic [AW-1:0] lg_adr [16];
    logic          lg_we  [16];
    logic [DW-1:0] lg_dat [16];
    logic [1:0]    lg_code[16];
    logic [DW-1:0] lg_rd  [16];
    logic [IW-1:0] lg_idx [16];
    bit            got_done, fail_seen, gap_ok, busy_after, first_ok;

    function automatic logic [AW-1:0] ent_adr(input int i);
        return 16'h1000 + 16'(i) * 16'h0111;
    endfunction
    function automatic logic [DW-1:0] ent_dat(input int i);
        return 16'h3C00 + 16'(i) * 16'h0007;
    endfunction

    task automatic load_table();
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            tbl_wr = 1'b1; tbl_idx = IW'(i); tbl_adr = ent_adr(i); tbl_dat = ent_dat(i);
        end
        @(negedge clk);
        tbl_wr = 1'b0;
    endtask

    task automatic run_cmd(input logic [1:0] mode, input int m1, input logic we,
                           input logic [DW-1:0] setm, input logic [DW-1:0] clrm,
                           input int inject_at);
        logic          p_cyc, p_stb, p_term, p_we;
        logic [AW-1:0] p_adr;
        logic [DW-1:0] p_dat;
        n_beats = 0; n_st = 0; rises = 0; chg = 0; extra_cyc = 0; stb_cycles = 0;
        got_done = 0; fail_seen = 0; gap_ok = 0; busy_after = 1; first_ok = 0;
        @(negedge clk); slv_rst = 1'b1;
        @(negedge clk); slv_rst = 1'b0;
        cmd_mode = mode; cmd_beats_m1 = IW'(m1); cmd_we = we; cmd_set = setm; cmd_clr = clrm;
        cmd_start = 1'b1;
        p_cyc = 0; p_stb = 0; p_term = 0; p_we = 0; p_adr = '0; p_dat = '0;
        for (int cyc_n = 0; cyc_n < 300; cyc_n++) begin
            @(negedge clk);
            cmd_start = (cyc_n == inject_at);
            if (cyc_n == inject_at) cmd_mode = 2'd1;
            if (cyc_n == 0) first_ok = wb_cyc && wb_stb && busy && wb_adr == ent_adr(0)
                                       && wb_dat_o == ent_dat(0);
            if (wb_cyc && !p_cyc) rises++;
            if (wb_stb) stb_cycles++;
            if (p_stb && !p_term && (wb_adr != p_adr || wb_dat_o != p_dat || wb_we != p_we))
                chg++;
            if (st_valid && n_st < 16) begin
                lg_code[n_st] = st_code; lg_rd[n_st] = st_rdata; lg_idx[n_st] = st_idx;
                n_st++;
            end
            if (wb_cyc && wb_stb && term && n_beats < 16) begin
                lg_adr[n_beats] = wb_adr; lg_we[n_beats] = wb_we; lg_dat[n_beats] = wb_dat_o;
                n_beats++;
            end
            if (done) begin
                got_done  = 1;
                fail_seen = done_fail;
                gap_ok    = !wb_cyc && !wb_stb && !wb_we && wb_adr == '0
                            && wb_dat_o == '0 && wb_sel == '0;
                @(negedge clk);
                cmd_start  = 1'b0;
                busy_after = busy;
                break;
            end
            p_cyc = wb_cyc; p_stb = wb_stb; p_term = term; p_we = wb_we;
            p_adr = wb_adr; p_dat = wb_dat_o;
        end
        cmd_start = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (wb_cyc) extra_cyc++;
        end
    endtask

    task automatic set_slave(input int w0, input int r0);
        for (int i = 0; i < 8; i++) begin
            wait_cfg[i] = w0; resp_cfg[i] = r0;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!wb_cyc && !wb_stb && !busy && !done, "R1 reset idle",
            {wb_cyc, wb_stb, busy, done}, 0);
    endtask

    task automatic t_single_read();
        set_slave(0, 1);
        run_cmd(2'd0, 5, 1'b0, '0, '0, -1);
        chk(first_ok, "R2 first cycle", first_ok, 1);
        chk(n_beats == 1 && !lg_we[0], "R2 single read one beat", n_beats, 1);
        chk(n_st == 1 && lg_code[0] == 2'd1 && lg_rd[0] == (ent_adr(0) ^ 16'hA5A5),
            "R3 status and read data", {lg_code[0], lg_rd[0]}, {2'd1, ent_adr(0) ^ 16'hA5A5});
        chk(got_done && gap_ok && !fail_seen, "R6 parked bus with done", {got_done, gap_ok, fail_seen}, 3'b110);
        chk(!busy_after, "R6 busy falls after gap", busy_after, 0);
    endtask

    task automatic t_single_write_waited();
        set_slave(3, 1);
        run_cmd(2'd3, 0, 1'b1, '0, '0, -1);
        chk(n_beats == 1 && lg_we[0] && lg_dat[0] == ent_dat(0), "R2 single write data",
            lg_dat[0], ent_dat(0));
        chk(stb_cycles == 4 && chg == 0, "R4 held over three waits", {stb_cycles, chg}, {32'd4, 32'd0});
    endtask

    task automatic t_block_read();
        bit ord = 1;
        set_slave(0, 1);
        for (int i = 0; i < 8; i++) wait_cfg[i] = i % 3;
        run_cmd(2'd1, 7, 1'b0, '0, '0, -1);
        for (int i = 0; i < 8; i++)
            if (lg_adr[i] != ent_adr(i) || lg_we[i] || lg_idx[i] != IW'(i)) ord = 0;
        chk(n_beats == 8 && ord, "R5 eight beats in table order", n_beats, 8);
        chk(rises == 1 && chg == 0, "R5 one unbroken cycle", rises, 1);
    endtask

    task automatic t_block_write_faults();
        bit dat_ok = 1;
        set_slave(1, 1);
        resp_cfg[1] = 2; resp_cfg[2] = 3; wait_cfg[2] = 0;
        run_cmd(2'd1, 3, 1'b1, '0, '0, -1);
        for (int i = 0; i < 4; i++) if (lg_dat[i] != ent_dat(i) || !lg_we[i]) dat_ok = 0;
        chk(n_beats == 4 && dat_ok, "R8 all beats run after err/rty", n_beats, 4);
        chk(lg_code[0] == 2'd1 && lg_code[1] == 2'd2 && lg_code[2] == 2'd3 && lg_code[3] == 2'd1,
            "R3 per-beat codes", {lg_code[0], lg_code[1], lg_code[2], lg_code[3]}, 8'b01101101);
        chk(fail_seen, "R8 done_fail set", fail_seen, 1);
    endtask

    task automatic t_rmw();
        logic [DW-1:0] rd, wr;
        set_slave(2, 1);
        run_cmd(2'd2, 0, 1'b1, 16'h00F0, 16'h0A01, -1);
        rd = ent_adr(0) ^ 16'hA5A5;
        wr = (rd | 16'h00F0) & ~16'h0A01;
        chk(n_beats == 2 && !lg_we[0] && lg_we[1] && lg_adr[0] == ent_adr(0)
            && lg_adr[1] == ent_adr(0), "R7 read then write same address", n_beats, 2);
        chk(lg_dat[1] == wr, "R7 merged write data", lg_dat[1], wr);
        chk(rises == 1 && !fail_seen, "R7 one cycle", rises, 1);
    endtask

    task automatic t_busy_start();
        set_slave(4, 1);
        run_cmd(2'd0, 0, 1'b0, '0, '0, 2);
        chk(n_beats == 1 && rises == 1, "R9 start while busy ignored", n_beats, 1);
        chk(extra_cyc == 0, "R9 no later cycle", extra_cyc, 0);
    endtask

    initial begin
        set_slave(0, 1);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        load_table();
        t_single_read();
        t_single_write_waited();
        t_block_read();
        t_block_write_faults();
        t_rmw();
        t_busy_start();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule